// File: doc/BRIEF.md
# Escaped Packet Byte Encoder

This block turns a packetised byte stream into a flat framed byte stream for a serial link. Input bytes arrive on a valid/ready port with start and end flags. Each packet goes out as a start marker, a channel marker and a channel number, followed by the payload. The end marker is placed just before the last payload byte, not after it. Any payload byte that equals a reserved character goes out as a two-byte escape pair.

The output port is always valid. When no packet byte is available, whether between packets or in a gap inside one, the idle character goes out in its place. The downstream serialiser sets the pace through `out_ready`. The encoder never stores payload. While it emits a framing or escape character, it keeps the offered input byte waiting by holding `in_ready` low.

Top module: `pkt_escape_framer`

## Requirements
- R1: Once a byte with `in_sop` set is offered outside a packet, the output is 0x7A, then 0x7C, then the channel number CHAN_ID (default 0x00), and then the payload.
- R2: The end marker 0x7B is output immediately before the final payload byte, which is the byte offered with `in_eop` set.
- R3: A payload byte of 0x7A, 0x7B, 0x7C or 0x7D is output as 0x7D and then the byte XOR 0x20.
- R4: A payload byte of 0x4A or 0x4D is output as 0x4D and then the byte XOR 0x20.
- R5: The output is 0x4A with `out_valid` high after reset, between packets, and in any cycle where a packet is open but `in_valid` is low.
- R6: When the final payload byte is reserved, the output order is the end marker, then the escape character, then the transformed byte.
- R7: `in_ready` is low in every cycle where a framing or escape character (0x7A, 0x7B, 0x7C, 0x7D, 0x4D) is output, and `in_ready` is never high while `out_ready` is low.
- R8: A one-byte packet with payload P produces exactly 0x7A, 0x7C, 0x00, 0x7B, P.
- R9: Outside a packet, an offered byte without `in_sop` is accepted and dropped. The output stays 0x4A.
- R10: While `out_ready` is low, the encoder does not advance. An inserted character stays on `out_data`, and the order of the byte stream does not depend on backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Payload byte offered |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte taken at this edge |
| out_data | output | DATA_W | Link byte |
| out_valid | output | 1 | Always high |
| out_ready | input | 1 | Link byte taken at this edge |

## Verification
The output byte is a combinational function of the encoder state and the offered input. It therefore appears in the same cycle as the input that causes it, and the state moves on at the rising edge where `out_ready` is high. The bench drives inputs at the falling edge and samples `out_data`, `out_ready` and `in_ready` one time unit later. A byte counts as sent, and an input byte as consumed, only when the sampled ready was high, and that sample is what the next rising edge acts on. The captured stream, with raw idle bytes removed, is compared against an encoding that bench functions compute from the packet list, under random input gaps and random `out_ready` stalls.

// File: rtl/pef_pkg.sv
package pef_pkg;
   // Link symbols; values are fixed by the framing protocol
   localparam logic [7:0] SYM_SOP  = 8'h7A;
   localparam logic [7:0] SYM_EOP  = 8'h7B;
   localparam logic [7:0] SYM_CHAN = 8'h7C;
   localparam logic [7:0] SYM_PESC = 8'h7D;
   localparam logic [7:0] SYM_IDLE = 8'h4A;
   localparam logic [7:0] SYM_LESC = 8'h4D;
   localparam logic [7:0] SYM_FLIP = 8'h20;

   // Reserved codes that need escaping, with a flag marking the link-layer group
   localparam int N_RSVD = 6;
   localparam logic [N_RSVD*8-1:0] RSVD_CODES = {8'h4D, 8'h4A, 8'h7D, 8'h7C, 8'h7B, 8'h7A};
   localparam logic [N_RSVD-1:0]   RSVD_LINK  = 6'b110000;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CHAN, ST_NUM, ST_BODY, ST_ESC
   } pef_state_e;

   typedef enum logic [2:0] {
      SEL_IDLE, SEL_SOP, SEL_CHAN, SEL_NUM, SEL_EOP, SEL_ESC, SEL_RAW, SEL_FLIP
   } pef_sel_e;
endpackage

// File: rtl/pef_classify.sv
module pef_classify
   import pef_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] byte_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] esc_o
);
   logic [N_RSVD-1:0] match;

   for (genvar g = 0; g < N_RSVD; g++) begin : g_cmp
      assign match[g] = (byte_i == DATA_W'(RSVD_CODES[g*8 +: 8]));
   end

   assign hit_o = |match;
   assign esc_o = (|(match & RSVD_LINK)) ? DATA_W'(SYM_LESC) : DATA_W'(SYM_PESC);
endmodule

// File: rtl/pef_fsm.sv
module pef_fsm
   import pef_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     in_valid,
   input  logic     in_sop,
   input  logic     in_eop,
   input  logic     hit,
   input  logic     out_ready,
   output pef_sel_e sel,
   output logic     in_ready
);
   pef_state_e state_q, state_d;
   logic       eop_done_q, eop_done_d;

   always_comb begin
      state_d    = state_q;
      eop_done_d = eop_done_q;
      sel        = SEL_IDLE;
      in_ready   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            eop_done_d = 1'b0;
            if (in_valid && in_sop) begin
               sel = SEL_SOP;
               if (out_ready) state_d = ST_CHAN;
            end else begin
               in_ready = out_ready;
            end
         end
         ST_CHAN: begin
            sel = SEL_CHAN;
            if (out_ready) state_d = ST_NUM;
         end
         ST_NUM: begin
            sel = SEL_NUM;
            if (out_ready) state_d = ST_BODY;
         end
         ST_BODY: begin
            if (!in_valid) begin
               sel = SEL_IDLE;
            end else if (in_eop && !eop_done_q) begin
               sel = SEL_EOP;
               if (out_ready) eop_done_d = 1'b1;
            end else if (hit) begin
               sel = SEL_ESC;
               if (out_ready) state_d = ST_ESC;
            end else begin
               sel      = SEL_RAW;
               in_ready = out_ready;
               if (out_ready && in_eop) begin
                  state_d    = ST_IDLE;
                  eop_done_d = 1'b0;
               end
            end
         end
         ST_ESC: begin
            sel      = SEL_FLIP;
            in_ready = out_ready;
            if (out_ready) begin
               state_d = in_eop ? ST_IDLE : ST_BODY;
               if (in_eop) eop_done_d = 1'b0;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         eop_done_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         eop_done_q <= eop_done_d;
      end
   end
endmodule

// File: rtl/pef_out_mux.sv
module pef_out_mux
   import pef_pkg::*;
#(
   parameter int              DATA_W  = 8,
   parameter logic [DATA_W-1:0] CHAN_ID = '0
) (
   input  pef_sel_e          sel,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] esc_i,
   output logic [DATA_W-1:0] data_o
);
   always_comb begin
      unique case (sel)
         SEL_SOP:  data_o = DATA_W'(SYM_SOP);
         SEL_CHAN: data_o = DATA_W'(SYM_CHAN);
         SEL_NUM:  data_o = CHAN_ID;
         SEL_EOP:  data_o = DATA_W'(SYM_EOP);
         SEL_ESC:  data_o = esc_i;
         SEL_RAW:  data_o = data_i;
         SEL_FLIP: data_o = data_i ^ DATA_W'(SYM_FLIP);
         default:  data_o = DATA_W'(SYM_IDLE);
      endcase
   end
endmodule

// File: rtl/pkt_escape_framer.sv
module pkt_escape_framer
   import pef_pkg::*;
#(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] CHAN_ID = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_ready
);
   if (DATA_W != 8) begin : g_bad_width
      $error("pkt_escape_framer: DATA_W must be 8");
   end

   logic              hit;
   logic [DATA_W-1:0] esc_char;
   pef_sel_e          sel;

   pef_classify #(.DATA_W(DATA_W)) classify_i (
      .byte_i (in_data),
      .hit_o  (hit),
      .esc_o  (esc_char)
   );

   pef_fsm fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_eop    (in_eop),
      .hit       (hit),
      .out_ready (out_ready),
      .sel       (sel),
      .in_ready  (in_ready)
   );

   pef_out_mux #(.DATA_W(DATA_W), .CHAN_ID(CHAN_ID)) mux_i (
      .sel    (sel),
      .data_i (in_data),
      .esc_i  (esc_char),
      .data_o (out_data)
   );

   assign out_valid = 1'b1;
endmodule

// File: rtl/pef_checker.sv
module pef_checker #(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] CHAN_ID = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] out_data,
   input logic              out_ready,
   input logic              in_ready
);
   logic inserted;
   assign inserted = (out_data == 8'h7A) || (out_data == 8'h7B) || (out_data == 8'h7C) ||
                     (out_data == 8'h7D) || (out_data == 8'h4D);

   // R1
   sop_then_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && out_data == 8'h7A) |=> (out_data == 8'h7C));
   // R1
   chan_then_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && out_data == 8'h7C) |=> (out_data == CHAN_ID));
   // R3
   pesc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && out_data == 8'h7D) |=>
      (out_data == 8'h5A || out_data == 8'h5B || out_data == 8'h5C || out_data == 8'h5D));
   // R4
   lesc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && out_data == 8'h4D) |=> (out_data == 8'h6A || out_data == 8'h6D));
   // R7
   hold_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inserted |-> !in_ready);
   // R7
   ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> out_ready);
   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_ready && inserted) |=> $stable(out_data));
endmodule

bind pkt_escape_framer pef_checker #(.DATA_W(DATA_W), .CHAN_ID(CHAN_ID)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_data  (out_data),
   .out_ready (out_ready),
   .in_ready  (in_ready)
);

// File: tb/pkt_escape_framer_tb_top.sv
`timescale 1ns/1ps
module pkt_escape_framer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_sop = 1'b0, in_eop = 1'b0, in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] out_data;
   logic       out_valid;
   logic       out_ready = 1'b0;

   int checks = 0, errors = 0, cycles = 0;
   bit timed_out = 1'b0;

   logic [9:0] in_q[$];   // {sop, eop, data}
   logic [7:0] exp_q[$];
   logic [7:0] rx_q[$];

   always #4 clk = ~clk;

   pkt_escape_framer dut_i (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
      .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
      .out_valid(out_valid), .out_ready(out_ready)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic bit is_pkt_rsvd(input logic [7:0] b);
      return b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D;
   endfunction

   function automatic bit is_link_rsvd(input logic [7:0] b);
      return b == 8'h4A || b == 8'h4D;
   endfunction

   // Queue a packet for driving and append its expected link encoding (R1..R4, R6)
   task automatic add_pkt(input logic [7:0] p[$]);
      int n = p.size();
      exp_q.push_back(8'h7A); exp_q.push_back(8'h7C); exp_q.push_back(8'h00);
      for (int i = 0; i < n; i++) begin
         in_q.push_back({(i == 0), (i == n - 1), p[i]});
         if (i == n - 1) exp_q.push_back(8'h7B);
         if (is_pkt_rsvd(p[i])) begin
            exp_q.push_back(8'h7D); exp_q.push_back(p[i] ^ 8'h20);
         end else if (is_link_rsvd(p[i])) begin
            exp_q.push_back(8'h4D); exp_q.push_back(p[i] ^ 8'h20);
         end else begin
            exp_q.push_back(p[i]);
         end
      end
   endtask

   task automatic run_phase(input string req, input int gap_pct, input int stall_pct);
      bit presenting = 1'b0;
      int hold_bad = 0, flush = 0;
      logic [7:0] got[$];
      rx_q.delete();
      while ((in_q.size() != 0 || presenting || flush < 8) && !timed_out) begin
         @(negedge clk);
         cycles++;
         if (cycles > 150000) timed_out = 1'b1;
         out_ready = ($urandom % 100) >= stall_pct;
         if (!presenting && in_q.size() != 0 && ($urandom % 100) >= gap_pct) begin
            presenting = 1'b1;
            {in_sop, in_eop, in_data} = in_q[0];
            in_valid = 1'b1;
         end else if (!presenting) begin
            in_valid = 1'b0;
            in_data  = $urandom;
         end
         if (in_q.size() == 0 && !presenting) begin
            flush++;
            out_ready = 1'b1;
         end
         #1;
         if (out_ready) rx_q.push_back(out_data);
         if ((out_data == 8'h7A || out_data == 8'h7B || out_data == 8'h7C ||
              out_data == 8'h7D || out_data == 8'h4D) && in_ready) hold_bad++;
         if (!out_ready && in_ready) hold_bad++;
         if (presenting && in_ready) begin
            void'(in_q.pop_front());
            presenting = 1'b0;
         end
      end
      foreach (rx_q[i]) if (rx_q[i] != 8'h4A) got.push_back(rx_q[i]);
      check({req, " length"}, got.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got.size(); i++) begin
         if (got[i] != exp_q[i]) begin
            check({req, " byte"}, got[i], exp_q[i]);
            break;
         end
      end
      checks++;  // content check counted once per phase
      check("R7 inserted char with in_ready high", hold_bad, 0);
      check("R5 idle after packet", out_data, 8'h4A);
      exp_q.delete();
   endtask

   initial begin
      logic [7:0] p[$];
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      #1;
      check("R5 idle in reset", out_data, 8'h4A);
      check("R5 valid in reset", out_valid, 1);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R5 idle after reset", out_data, 8'h4A);

      // R8 one-byte packet, R2 end marker ahead of the byte
      p = '{8'h11}; add_pkt(p);
      run_phase("R8 single byte", 0, 0);

      // R3 R4 every reserved code in the middle of a packet
      p = '{8'h01, 8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h4A, 8'h4D, 8'h55}; add_pkt(p);
      run_phase("R3 R4 reserved payload", 0, 0);

      // R6 escaped final byte, both escape groups
      p = '{8'h22, 8'h7D}; add_pkt(p);
      p = '{8'h4A}; add_pkt(p);
      run_phase("R6 escaped last byte", 0, 0);

      // R9 bytes without a start flag outside a packet are dropped
      in_q.push_back({2'b00, 8'h33}); in_q.push_back({2'b01, 8'h7A});
      p = '{8'h44, 8'h45}; add_pkt(p);
      in_q.push_back({2'b00, 8'h66});
      run_phase("R9 stray bytes dropped", 0, 0);

      // R10 heavy stalls on directed reserved content
      p = '{8'h7B, 8'h4D, 8'h00, 8'h7C}; add_pkt(p);
      run_phase("R10 backpressure", 30, 60);

      // R1 R2 R5 R10 random packets with gaps and stalls
      for (int k = 0; k < 60; k++) begin
         int n = 1 + ($urandom % 7);
         p.delete();
         for (int j = 0; j < n; j++) begin
            logic [7:0] rs[6] = '{8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h4A, 8'h4D};
            if (($urandom % 100) < 30) p.push_back(rs[$urandom % 6]);
            else p.push_back(8'($urandom));
         end
         add_pkt(p);
      end
      run_phase("R1 R2 random stream", 25, 35);

      if (timed_out) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1500000;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
   end
endmodule